// File: doc/BRIEF.md
# Boundary-Scan Output Bus Tri-State Control

This block is a compact IEEE 1149.1 test access port that sits in front of a device's parallel output bus. In normal operation the bus pins and their shared output enable pass straight through from the functional logic. Under the external-test instruction the pins are instead driven from the update stage of a boundary-scan register. One dedicated cell of that register decides whether the whole bus drives or floats.

The gating cell occupies a fixed position in the scan chain. That position is a parameter, chosen by a package-variant parameter (index 85 or 89 by default). Its update stage comes up in the driving state after reset and again whenever the controller passes through Test-Logic-Reset. The ordinary data cells clear to 0 instead. Test software shifts the desired pin values and the gating bit in serially through the data input, and then commits them with Update-DR. A high-impedance bus is modelled by `bus_oe` low. The serial output's high impedance is modelled by `tdo_oe` low.

Top module: `tap_bus_ctrl`

## Requirements
- R1: Five consecutive rising `tck` edges with `tms` high bring the controller to Test-Logic-Reset from any state, and so does `rst` high at a rising edge. In that state the current instruction becomes IDCODE.
- R2: The instruction register is 3 bits wide and shifts in LSB first. The codes are 000 = EXTEST, 001 = IDCODE, 100 = SAMPLE/PRELOAD and 111 = BYPASS. Every other code behaves as BYPASS. Capture-IR loads 001, so the first three bits shifted out are 1, 0, 0.
- R3: Under BYPASS the data path is one bit long. Capture-DR loads 0, and each bit presented on `tdi` appears on `tdo` one shift later.
- R4: Under SAMPLE/PRELOAD or EXTEST the boundary register is N_PINS+1 cells long. `tdi` enters at the highest index and `tdo` shows index 0. Chain index CTRL_IDX is the gating cell. Pin p sits at index p below CTRL_IDX and at index p+1 otherwise.
- R5: Update-DR under SAMPLE/PRELOAD or EXTEST copies every shift cell into its update stage. Under any other instruction the update stage is left unchanged.
- R6: While EXTEST is current, `pin_out` equals the data cells' update stage and `bus_oe` equals the gating cell's update stage. A 0 in the gating cell floats the whole bus.
- R7: While EXTEST is not current, `pin_out` equals `func_data` and `bus_oe` equals `func_oe`, whatever the update stage holds.
- R8: Reset and Test-Logic-Reset set the gating cell's update stage to 1 and clear the data cells' update stage to 0.
- R9: Capture-DR under SAMPLE/PRELOAD or EXTEST loads each data cell from its current `pin_out` value and loads the gating cell from its own update stage.
- R10: `tdo` and `tdo_oe` change only on the falling edge of `tck`. `tdo_oe` is high only in Shift-DR and Shift-IR.
- R11: Under IDCODE, Capture-DR loads the ID_W-bit value ID_VALUE, which is then shifted out LSB first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high test reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| func_data | input | N_PINS | Functional output bus values |
| func_oe | input | 1 | Functional bus-wide output enable |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | High while `tdo` drives (shift states) |
| pin_out | output | N_PINS | Final per-pin output values |
| bus_oe | output | 1 | Final bus-wide output enable (0 = high impedance) |

## Verification
The bench builds the block with N_PINS = 8 and CTRL_IDX = 5, which places the gating cell inside the chain. Pins on both sides of it are therefore checked for the one-position skip in the index mapping. The 9-cell chain keeps full capture-and-shift passes short, so capture contents, preloaded patterns and the gating bit can each be compared bit for bit on `tdo`. A 32-bit ID_VALUE with distinct nibbles makes any bit-order error visible in the IDCODE read-out.

// File: rtl/tapctl_pkg.sv
`timescale 1ns/1ps
package tapctl_pkg;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {
    PATH_BYPASS, PATH_IDCODE, PATH_CHAIN
  } dr_path_e;

  localparam int          OPW        = 3;
  localparam logic [OPW-1:0] OP_EXTEST = 3'b000;
  localparam logic [OPW-1:0] OP_IDCODE = 3'b001;
  localparam logic [OPW-1:0] OP_SAMPLE = 3'b100;
  localparam logic [OPW-1:0] OP_BYPASS = 3'b111;
  localparam logic [OPW-1:0] OP_CAPTURE = 3'b001;

endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
  import tapctl_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PA_DR;
      ST_PA_DR:  nxt = tms ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PA_IR;
      ST_PA_IR:  nxt = tms ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      default:   nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge tck) begin
    if (rst) state <= ST_RESET;
    else     state <= nxt;
  end

endmodule

// File: rtl/tap_instr.sv
`timescale 1ns/1ps
module tap_instr
  import tapctl_pkg::*;
(
  input  logic           tck,
  input  logic           rst,
  input  logic           tdi,
  input  tap_state_e     state,
  output logic           ir_tdo,
  output logic [OPW-1:0] ir_cur,
  output dr_path_e       dr_path,
  output logic           extest
);

  logic [OPW-1:0] ir_sh;

  always_ff @(posedge tck) begin
    if (rst || state == ST_RESET) begin
      ir_sh  <= OP_CAPTURE;
      ir_cur <= OP_IDCODE;
    end else begin
      case (state)
        ST_CAP_IR: ir_sh  <= OP_CAPTURE;
        ST_SH_IR:  ir_sh  <= {tdi, ir_sh[OPW-1:1]};
        ST_UPD_IR: ir_cur <= ir_sh;
        default: ;
      endcase
    end
  end

  assign ir_tdo = ir_sh[0];

  always_comb begin
    extest  = 1'b0;
    dr_path = PATH_BYPASS;
    case (ir_cur)
      OP_EXTEST: begin dr_path = PATH_CHAIN; extest = 1'b1; end
      OP_SAMPLE: dr_path = PATH_CHAIN;
      OP_IDCODE: dr_path = PATH_IDCODE;
      default:   dr_path = PATH_BYPASS;
    endcase
  end

endmodule

// File: rtl/bscan_chain.sv
`timescale 1ns/1ps
module bscan_chain
  import tapctl_pkg::*;
#(
  parameter int N_PINS   = 96,
  parameter int CTRL_IDX = 85
) (
  input  logic              tck,
  input  logic              rst,
  input  logic              tdi,
  input  tap_state_e        state,
  input  logic              sel,
  input  logic [N_PINS-1:0] pin_now,
  output logic              ser_out,
  output logic [N_PINS-1:0] upd_data,
  output logic              upd_ctrl
);

  localparam int LEN = N_PINS + 1;
  localparam logic [LEN-1:0] UPD_INIT = {{(LEN-1){1'b0}}, 1'b1} << CTRL_IDX;

  logic [LEN-1:0] sh;
  logic [LEN-1:0] upd;
  logic [LEN-1:0] cap;

  for (genvar i = 0; i < LEN; i++) begin : g_cell
    if (i == CTRL_IDX) begin : g_ctl
      assign cap[i] = upd[i];
    end else if (i < CTRL_IDX) begin : g_lo
      assign cap[i] = pin_now[i];
    end else begin : g_hi
      assign cap[i] = pin_now[i-1];
    end
  end

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    if (p < CTRL_IDX) begin : g_lo
      assign upd_data[p] = upd[p];
    end else begin : g_hi
      assign upd_data[p] = upd[p+1];
    end
  end

  always_ff @(posedge tck) begin
    if (rst || state == ST_RESET) begin
      sh  <= '0;
      upd <= UPD_INIT;
    end else if (sel) begin
      case (state)
        ST_CAP_DR: sh  <= cap;
        ST_SH_DR:  sh  <= {tdi, sh[LEN-1:1]};
        ST_UPD_DR: upd <= sh;
        default: ;
      endcase
    end
  end

  assign ser_out  = sh[0];
  assign upd_ctrl = upd[CTRL_IDX];

endmodule

// File: rtl/tap_bus_ctrl.sv
`timescale 1ns/1ps
module tap_bus_ctrl
  import tapctl_pkg::*;
#(
  parameter int          N_PINS    = 96,
  parameter bit          PACKAGE_B = 1'b0,
  parameter int          CTRL_IDX  = PACKAGE_B ? 89 : 85,
  parameter int          ID_W      = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h0A5C_3001
) (
  input  logic              tck,
  input  logic              rst,
  input  logic              tms,
  input  logic              tdi,
  input  logic [N_PINS-1:0] func_data,
  input  logic              func_oe,
  output logic              tdo,
  output logic              tdo_oe,
  output logic [N_PINS-1:0] pin_out,
  output logic              bus_oe
);

  tap_state_e     state;
  dr_path_e       dr_path;
  logic [OPW-1:0] ir_cur;
  logic           ir_tdo, extest, chain_tdo, ctrl_upd;
  logic [N_PINS-1:0] data_upd;
  logic           bypass_q;
  logic [ID_W-1:0] id_sh;

  tap_fsm u_fsm (.tck(tck), .rst(rst), .tms(tms), .state(state));

  tap_instr u_ir (
    .tck(tck), .rst(rst), .tdi(tdi), .state(state),
    .ir_tdo(ir_tdo), .ir_cur(ir_cur), .dr_path(dr_path), .extest(extest)
  );

  bscan_chain #(.N_PINS(N_PINS), .CTRL_IDX(CTRL_IDX)) u_chain (
    .tck(tck), .rst(rst), .tdi(tdi), .state(state),
    .sel(dr_path == PATH_CHAIN), .pin_now(pin_out),
    .ser_out(chain_tdo), .upd_data(data_upd), .upd_ctrl(ctrl_upd)
  );

  always_ff @(posedge tck) begin
    if (rst) begin
      bypass_q <= 1'b0;
      id_sh    <= '0;
    end else if (state == ST_CAP_DR) begin
      bypass_q <= 1'b0;
      id_sh    <= ID_VALUE;
    end else if (state == ST_SH_DR) begin
      bypass_q <= tdi;
      id_sh    <= {tdi, id_sh[ID_W-1:1]};
    end
  end

  always_comb begin
    if (extest) begin
      pin_out = data_upd;
      bus_oe  = ctrl_upd;
    end else begin
      pin_out = func_data;
      bus_oe  = func_oe;
    end
  end

  always_ff @(negedge tck) begin
    if (rst) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (state == ST_SH_DR) || (state == ST_SH_IR);
      if (state == ST_SH_IR) tdo <= ir_tdo;
      else if (state == ST_SH_DR) begin
        case (dr_path)
          PATH_CHAIN:  tdo <= chain_tdo;
          PATH_IDCODE: tdo <= id_sh[0];
          default:     tdo <= bypass_q;
        endcase
      end else tdo <= 1'b0;
    end
  end

endmodule

// File: rtl/tap_bus_ctrl_chk.sv
`timescale 1ns/1ps
module tap_bus_ctrl_chk
  import tapctl_pkg::*;
(
  input logic           tck,
  input logic           rst,
  input logic           tms,
  input logic           tdi,
  input tap_state_e     state,
  input logic [OPW-1:0] ir_cur,
  input dr_path_e       dr_path,
  input logic           extest,
  input logic           func_oe,
  input logic           bus_oe,
  input logic           ctrl_upd,
  input logic           tdo_oe,
  input logic           bypass_q
);

  assert_tms_reset_R1: assert property (@(posedge tck) disable iff (rst)
    (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
      |=> state == ST_RESET);

  assert_reserved_bypass_R2: assert property (@(posedge tck) disable iff (rst)
    (ir_cur != OP_EXTEST && ir_cur != OP_IDCODE && ir_cur != OP_SAMPLE)
      |-> dr_path == PATH_BYPASS);

  assert_bypass_delay_R3: assert property (@(posedge tck) disable iff (rst)
    (state == ST_SH_DR) |=> bypass_q == $past(tdi));

  assert_extest_gate_R6: assert property (@(posedge tck) disable iff (rst)
    extest |-> bus_oe == ctrl_upd);

  assert_functional_oe_R7: assert property (@(posedge tck) disable iff (rst)
    !extest |-> bus_oe == func_oe);

  assert_reset_preset_R8: assert property (@(posedge tck) disable iff (rst)
    (state == ST_RESET) |=> ctrl_upd);

  assert_tdo_window_R10: assert property (@(posedge tck) disable iff (rst)
    tdo_oe == (state == ST_SH_DR || state == ST_SH_IR));

endmodule

bind tap_bus_ctrl tap_bus_ctrl_chk u_chk (
  .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .state(state),
  .ir_cur(ir_cur), .dr_path(dr_path), .extest(extest),
  .func_oe(func_oe), .bus_oe(bus_oe), .ctrl_upd(ctrl_upd),
  .tdo_oe(tdo_oe), .bypass_q(bypass_q)
);

// File: tb/tap_bus_ctrl_test.sv
`timescale 1ns/1ps
module tap_bus_ctrl_test;

  localparam int NP  = 8;
  localparam int CI  = 5;
  localparam int LEN = NP + 1;
  localparam logic [31:0] IDV = 32'h1234_5679;

  logic tck = 1'b0, rst = 1'b1, tms = 1'b1, tdi = 1'b0;
  logic [NP-1:0] func_data = 8'hA5;
  logic func_oe = 1'b0;
  logic tdo, tdo_oe, bus_oe;
  logic [NP-1:0] pin_out;

  always #2.5 tck = ~tck;

  tap_bus_ctrl #(.N_PINS(NP), .CTRL_IDX(CI), .ID_W(32), .ID_VALUE(IDV)) uut (
    .tck(tck), .rst(rst), .tms(tms), .tdi(tdi),
    .func_data(func_data), .func_oe(func_oe),
    .tdo(tdo), .tdo_oe(tdo_oe), .pin_out(pin_out), .bus_oe(bus_oe)
  );

  int  n_chk = 0, n_fail = 0;
  bit  finished = 1'b0;
  logic [63:0] exp_q[$];
  logic [63:0] obs_q[$];
  string       tag_q[$];
  event        sb_ev;

  task automatic sb_push(input string tag, input logic [63:0] obs, input logic [63:0] exp);
    obs_q.push_back(obs);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    -> sb_ev;
  endtask

  task automatic sb_drain();
    while (obs_q.size() > 0) begin
      logic [63:0] o, e;
      string t;
      o = obs_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (o !== e) begin
        n_fail++;
        $display("FAIL %s: actual %0h expected %0h", t, o, e);
      end
    end
  endtask

  initial forever begin
    @(sb_ev);
    sb_drain();
  end

  function automatic logic [LEN-1:0] chain_of(input logic [NP-1:0] d, input logic c);
    logic [LEN-1:0] v;
    for (int i = 0; i < LEN; i++)
      v[i] = (i == CI) ? c : (i < CI) ? d[i] : d[i-1];
    return v;
  endfunction

  task automatic step(input logic tms_v, input logic tdi_v, output logic o, output logic e);
    @(negedge tck); #1;
    o = tdo;
    e = tdo_oe;
    tms = tms_v;
    tdi = tdi_v;
  endtask

  task automatic settle();
    @(negedge tck); #1;
  endtask

  task automatic load_ir(input logic [2:0] code);
    logic o, e;
    logic [2:0] cap;
    step(1'b1, 1'b0, o, e);
    step(1'b1, 1'b0, o, e);
    step(1'b0, 1'b0, o, e);
    step(1'b0, 1'b0, o, e);
    for (int i = 0; i < 3; i++) begin
      step(i == 2, code[i], o, e);
      cap[i] = o;
    end
    step(1'b1, 1'b0, o, e);
    step(1'b0, 1'b0, o, e);
    settle();
    sb_push("R2 capture-IR pattern", 64'(cap), 64'(3'b001));
  endtask

  task automatic scan_dr(input logic [63:0] din, input int n,
                         output logic [63:0] dout, output logic oe_all, output logic oe_after);
    logic o, e;
    dout = '0;
    oe_all = 1'b1;
    step(1'b1, 1'b0, o, e);
    step(1'b0, 1'b0, o, e);
    step(1'b0, 1'b0, o, e);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], o, e);
      dout[i] = o;
      oe_all &= e;
    end
    step(1'b1, 1'b0, o, e);
    oe_after = e;
    step(1'b0, 1'b0, o, e);
    settle();
  endtask

  initial begin
    logic [63:0] d;
    logic oa, ob, o, e;
    repeat (4) @(posedge tck);
    @(negedge tck); #1;
    rst = 1'b0;
    settle();
    sb_push("R10 tdo_oe low after reset", 64'(tdo_oe), 64'd0);
    sb_push("R7 pins follow func after reset", 64'(pin_out), 64'(8'hA5));
    sb_push("R7 bus_oe follows func after reset", 64'(bus_oe), 64'd0);
    step(1'b0, 1'b0, o, e);

    load_ir(3'b000);
    sb_push("R8 gating cell preset drives", 64'(bus_oe), 64'd1);
    sb_push("R8 data cells cleared", 64'(pin_out), 64'd0);

    scan_dr(64'(chain_of(8'h3C, 1'b0)), LEN, d, oa, ob);
    sb_push("R9 capture pins and gate under EXTEST", d, 64'(chain_of(8'h00, 1'b1)));
    sb_push("R10 tdo_oe high while shifting", 64'(oa), 64'd1);
    sb_push("R10 tdo_oe low after shift", 64'(ob), 64'd0);
    sb_push("R6 gate 0 floats bus", 64'(bus_oe), 64'd0);
    sb_push("R5 update drives preloaded data", 64'(pin_out), 64'(8'h3C));

    scan_dr(64'(chain_of(8'hC3, 1'b1)), LEN, d, oa, ob);
    sb_push("R4 chain order and length on tdo", d, 64'(chain_of(8'h3C, 1'b0)));
    sb_push("R6 gate 1 drives bus", 64'(bus_oe), 64'd1);
    sb_push("R5 second preload on pins", 64'(pin_out), 64'(8'hC3));

    func_data = 8'h5A;
    func_oe   = 1'b0;
    load_ir(3'b100);
    sb_push("R7 pins follow func under SAMPLE", 64'(pin_out), 64'(8'h5A));
    scan_dr(64'(chain_of(8'hFF, 1'b0)), LEN, d, oa, ob);
    sb_push("R9 capture func pins and gate under SAMPLE", d, 64'(chain_of(8'h5A, 1'b1)));
    sb_push("R7 preload does not reach pins", 64'(pin_out), 64'(8'h5A));
    sb_push("R7 preload does not reach bus_oe", 64'(bus_oe), 64'd0);

    func_oe = 1'b1;
    load_ir(3'b000);
    sb_push("R5 SAMPLE preload applied by EXTEST", 64'(pin_out), 64'(8'hFF));
    sb_push("R6 preloaded gate 0 overrides func_oe", 64'(bus_oe), 64'd0);

    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o, e);
    step(1'b0, 1'b0, o, e);
    settle();
    sb_push("R1 TMS reset returns to functional pins", 64'(pin_out), 64'(8'h5A));
    sb_push("R1 TMS reset returns to functional oe", 64'(bus_oe), 64'd1);
    func_oe = 1'b0;
    load_ir(3'b000);
    sb_push("R8 gate preset after TMS reset", 64'(bus_oe), 64'd1);
    sb_push("R8 data cleared after TMS reset", 64'(pin_out), 64'd0);

    load_ir(3'b111);
    scan_dr(64'(10'b1101001011), 10, d, oa, ob);
    sb_push("R3 bypass one-bit delay", d, 64'(10'b1010010110));

    load_ir(3'b010);
    scan_dr(64'(4'b1011), 4, d, oa, ob);
    sb_push("R2 reserved code acts as bypass", d, 64'(4'b0110));
    sb_push("R7 reserved code keeps functional pins", 64'(pin_out), 64'(8'h5A));

    load_ir(3'b001);
    scan_dr(64'd0, 32, d, oa, ob);
    sb_push("R11 IDCODE read-out LSB first", d, 64'(IDV));

    #20;
    sb_drain();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1'b1;
      sb_drain();
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule